// File: doc/BRIEF.md
# Group Semaphore Reset Engine

This block executes a bulk semaphore re-arm instruction against a bank of semaphores, 256 by default. It accepts one 64-byte instruction word over a valid/ready handshake and checks the word. It then walks the bank one group of lanes at a time and drives a clear port. On that port, a word index plus a lane mask names the semaphores to be zeroed in that cycle.

The instruction has two encodings. A range form zeroes every semaphore from a first index up to a last index. A scattered form carries a mask with one bit per semaphore. A malformed or empty instruction raises a one-cycle error flag, and the bank is not touched. A completed walk ends with a one-cycle done pulse.

Top module: `grp_sem_reset`

## Requirements
- R1: `req_ready` is high whenever no walk is in progress and low during every cycle of a walk. A word is taken only in a cycle where `req_valid` and `req_ready` are both high.
- R2: A taken word is rejected as illegal in two cases: byte 0 (bits 7:0) is not 0xB0, or the mode byte 12 (bits 103:96) is neither 0x01 nor 0x02. On rejection, `err_illegal` is high for exactly the cycle after acceptance, no clear is issued and `done` stays low. At most one error flag is ever high.
- R3: In mode 0x01, every semaphore whose index lies in the inclusive range from byte 13 (bits 111:104) to byte 14 (bits 119:112) is cleared, and no other semaphore is. This holds for a single-entry range and for the full range 0 to 255. In this mode the mask bytes have no effect.
- R4: In mode 0x01 with the first index greater than the last, `err_order` pulses in the cycle after acceptance and nothing is cleared.
- R5: In mode 0x02, the cleared set equals a 256-bit mask held in bytes 32 to 63. The mask is eight little-endian 32-bit words, and semaphore n is selected by bit n mod 32 of word n/32, which is word bit 256+n. In this mode the range bytes have no effect.
- R6: In mode 0x02 with an all-zero mask, `err_empty` pulses in the cycle after acceptance and nothing is cleared.
- R7: A walk visits word indices 0 to 7 in ascending order, one per cycle, starting in the cycle after acceptance. In each cycle where `clr_valid` is high, bit b of `clr_mask` clears semaphore `clr_idx`*32+b. `clr_valid` is high only when that mask is non-zero.
- R8: `done` is high for exactly one cycle, the cycle after the last word slot, which is the ninth cycle after acceptance. It is never high together with `clr_valid`.
- R9: After reset, `req_ready` is high and `clr_valid`, `done` and all error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Instruction word offered |
| req_ready | output | 1 | Engine idle, word may be taken |
| req_word | input | 512 | 64-byte instruction, byte k at bits 8k+7:8k |
| clr_valid | output | 1 | Clear strobe for the bank |
| clr_idx | output | log2(SEM_COUNT/LANES) | Word index of the lanes being cleared |
| clr_mask | output | LANES | Lanes of that word to zero |
| done | output | 1 | One-cycle pulse when a walk completes |
| err_illegal | output | 1 | Bad opcode or clear mode |
| err_order | output | 1 | Range with first above last |
| err_empty | output | 1 | Mask selects no semaphore |

## Verification
The bench builds the block with its default values: 256 semaphores cleared 32 lanes per cycle, which gives eight word slots per walk. With these values both index extremes, 0 and 255, as well as the word boundaries at multiples of 32, can be reached. A range crossing several words then produces partial masks at both ends and full masks in between. Random mixes of sparse masks, including all-zero words that must raise no strobe, are checked against a bank model rebuilt from the clear port.

// File: rtl/grp_sem_reset.sv
`timescale 1ns/1ps
module grp_sem_reset #(
  parameter int SEM_COUNT = 256,
  parameter int LANES = 32,
  parameter logic [7:0] OPCODE = 8'hB0
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic [511:0]                         req_word,
  output logic                                 clr_valid,
  output logic [$clog2(SEM_COUNT/LANES)-1:0]   clr_idx,
  output logic [LANES-1:0]                     clr_mask,
  output logic                                 done,
  output logic                                 err_illegal,
  output logic                                 err_order,
  output logic                                 err_empty
);
  localparam int WORDS = SEM_COUNT / LANES;
  localparam int CW = $clog2(WORDS);
  localparam logic [7:0] MODE_RANGE = 8'h01;
  localparam logic [7:0] MODE_MASK  = 8'h02;
  localparam logic [CW-1:0] LAST_W = CW'(WORDS - 1);

  logic [7:0] op_b, mode_b, first_b, last_b;
  logic [SEM_COUNT-1:0] mask_in;
  assign op_b    = req_word[7:0];
  assign mode_b  = req_word[103:96];
  assign first_b = req_word[111:104];
  assign last_b  = req_word[119:112];
  assign mask_in = req_word[256 +: SEM_COUNT];

  logic accept, bad_ins, bad_order, bad_empty, go;
  assign accept    = req_valid & req_ready;
  assign bad_ins   = (op_b != OPCODE) || (mode_b != MODE_RANGE && mode_b != MODE_MASK);
  assign bad_order = !bad_ins && mode_b == MODE_RANGE && first_b > last_b;
  assign bad_empty = !bad_ins && mode_b == MODE_MASK && mask_in == '0;
  assign go        = accept && !bad_ins && !bad_order && !bad_empty;

  logic                 busy, is_range;
  logic [CW-1:0]        cnt;
  logic [7:0]           first_q, last_q;
  logic [SEM_COUNT-1:0] mask_q;
  logic [LANES-1:0]     rng_bits, word_mask;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign rng_bits[b] = (int'(cnt) * LANES + b >= int'(first_q)) &&
                         (int'(cnt) * LANES + b <= int'(last_q));
  end

  assign word_mask = is_range ? rng_bits : mask_q[cnt*LANES +: LANES];
  assign req_ready = !busy;
  assign clr_idx   = cnt;
  assign clr_mask  = busy ? word_mask : '0;
  assign clr_valid = busy && (word_mask != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      is_range    <= 1'b0;
      cnt         <= '0;
      first_q     <= '0;
      last_q      <= '0;
      mask_q      <= '0;
      done        <= 1'b0;
      err_illegal <= 1'b0;
      err_order   <= 1'b0;
      err_empty   <= 1'b0;
    end else begin
      done        <= busy && cnt == LAST_W;
      err_illegal <= accept && bad_ins;
      err_order   <= accept && bad_order;
      err_empty   <= accept && bad_empty;
      if (go) begin
        busy     <= 1'b1;
        cnt      <= '0;
        is_range <= (mode_b == MODE_RANGE);
        first_q  <= first_b;
        last_q   <= last_b;
        mask_q   <= mask_in;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST_W) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/grp_sem_reset_chk.sv
`timescale 1ns/1ps
module grp_sem_reset_chk #(
  parameter int SEM_COUNT = 256,
  parameter int LANES = 32,
  parameter logic [7:0] OPCODE = 8'hB0
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               req_valid,
  input logic                               req_ready,
  input logic [511:0]                       req_word,
  input logic                               clr_valid,
  input logic [$clog2(SEM_COUNT/LANES)-1:0] clr_idx,
  input logic [LANES-1:0]                   clr_mask,
  input logic                               done,
  input logic                               err_illegal,
  input logic                               err_order,
  input logic                               err_empty
);
  logic taken, op_ok, is_rng, is_msk;
  assign taken  = req_valid && req_ready;
  assign op_ok  = req_word[7:0] == OPCODE;
  assign is_rng = req_word[103:96] == 8'h01;
  assign is_msk = req_word[103:96] == 8'h02;

  assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> !req_ready);

  assert_illegal_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && (!op_ok || (!is_rng && !is_msk))) |=> (err_illegal && !clr_valid && !done));

  assert_one_error_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_illegal, err_order, err_empty}));

  assert_reversed_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && op_ok && is_rng && req_word[111:104] > req_word[119:112]) |=> (err_order && !clr_valid));

  assert_empty_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && op_ok && is_msk && req_word[256 +: SEM_COUNT] == '0) |=> (err_empty && !clr_valid));

  assert_strobe_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> clr_mask != '0);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_no_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !clr_valid);
endmodule

bind grp_sem_reset grp_sem_reset_chk #(.SEM_COUNT(SEM_COUNT), .LANES(LANES), .OPCODE(OPCODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_word(req_word),
  .clr_valid(clr_valid), .clr_idx(clr_idx), .clr_mask(clr_mask), .done(done),
  .err_illegal(err_illegal), .err_order(err_order), .err_empty(err_empty)
);

// File: tb/tb_grp_sem_reset.sv
`timescale 1ns/1ps
module tb_grp_sem_reset;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [511:0] req_word = '0;
  logic clr_valid, done, err_illegal, err_order, err_empty;
  logic [2:0] clr_idx;
  logic [31:0] clr_mask;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  grp_sem_reset dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_word(req_word),
    .clr_valid(clr_valid), .clr_idx(clr_idx), .clr_mask(clr_mask), .done(done),
    .err_illegal(err_illegal), .err_order(err_order), .err_empty(err_empty)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [511:0] mk(input logic [7:0] op, input logic [7:0] mode,
                                      input logic [7:0] f, input logic [7:0] l,
                                      input logic [255:0] m);
    logic [511:0] w = '0;
    w[7:0] = op; w[103:96] = mode; w[111:104] = f; w[119:112] = l; w[511:256] = m;
    return w;
  endfunction

  function automatic logic [255:0] rmask(input int f, input int l);
    logic [255:0] r = '0;
    for (int i = 0; i < 256; i++) r[i] = (i >= f) && (i <= l);
    return r;
  endfunction

  // err code: 0 none, 1 illegal, 2 order, 3 empty
  task automatic run_case(input logic [511:0] w, input string tag);
    logic [255:0] exp_set, got;
    int exp_err, done_k, err_k, err_code, bad_idx;
    bit ready_k1;
    exp_set = '0; exp_err = 0;
    if (w[7:0] != 8'hB0 || (w[103:96] != 8'h01 && w[103:96] != 8'h02)) exp_err = 1;
    else if (w[103:96] == 8'h01) begin
      if (w[111:104] > w[119:112]) exp_err = 2;
      else exp_set = rmask(int'(w[111:104]), int'(w[119:112]));
    end else begin
      if (w[511:256] == '0) exp_err = 3;
      else exp_set = w[511:256];
    end
    got = '0; done_k = 0; err_k = 0; err_code = 0; bad_idx = 0; ready_k1 = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_word = w;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= 12; k++) begin
      if (k > 1) @(negedge clk);
      if (k == 1) ready_k1 = req_ready;
      if (clr_valid) begin
        if (int'(clr_idx) != k - 1 || clr_mask == '0) bad_idx++;
        got[int'(clr_idx)*32 +: 32] = got[int'(clr_idx)*32 +: 32] | clr_mask;
      end
      if (done && done_k == 0) done_k = k;
      if (err_illegal || err_order || err_empty) begin
        if (err_k == 0) err_k = k;
        err_code = err_illegal ? 1 : err_order ? 2 : 3;
      end
    end
    if (exp_err == 0) begin
      chk(ready_k1 == 1'b0, "R1", {tag, " ready low during walk"}, 256'(ready_k1), 256'(0));
      chk(got == exp_set, (w[103:96] == 8'h01) ? "R3" : "R5", {tag, " cleared set"}, got, exp_set);
      chk(bad_idx == 0, "R7", {tag, " word order or empty strobe"}, 256'(bad_idx), 256'(0));
      chk(done_k == 9 && err_k == 0, "R8", {tag, " done cycle"}, 256'(done_k), 256'(9));
    end else begin
      chk(err_k == 1 && err_code == exp_err,
          exp_err == 1 ? "R2" : exp_err == 2 ? "R4" : "R6",
          {tag, " error flag"}, 256'(err_code), 256'(exp_err));
      chk(got == '0 && done_k == 0, exp_err == 1 ? "R2" : exp_err == 2 ? "R4" : "R6",
          {tag, " nothing cleared"}, got, 256'(0));
      chk(ready_k1 == 1'b1, "R1", {tag, " ready after reject"}, 256'(ready_k1), 256'(1));
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(req_ready && !clr_valid && !done && !err_illegal && !err_order && !err_empty,
        "R9", "reset state", {250'(0), req_ready, clr_valid, done, err_illegal, err_order, err_empty},
        256'h20);
    rst_n = 1'b1;
    @(negedge clk);
    run_case(mk(8'hB0, 8'h01, 8'd0, 8'd255, '0), "R3 full range");
    run_case(mk(8'hB0, 8'h01, 8'd7, 8'd7, '0), "R3 single");
    run_case(mk(8'hB0, 8'h01, 8'd31, 8'd32, {256{1'b1}}), "R3 word edge, mask ignored");
    run_case(mk(8'hB0, 8'h01, 8'd255, 8'd255, '0), "R3 top index");
    run_case(mk(8'hB0, 8'h01, 8'd9, 8'd8, '0), "R4 reversed");
    run_case(mk(8'hB0, 8'h02, 8'd0, 8'd0, 256'd1 << 255), "R5 bit 255");
    run_case(mk(8'hB0, 8'h02, 8'd200, 8'd3, 256'd1 | (256'd1 << 224)), "R5 words 0 and 7, range ignored");
    run_case(mk(8'hB0, 8'h02, 8'd0, 8'd10, '0), "R6 empty");
    run_case(mk(8'hB1, 8'h01, 8'd0, 8'd10, '0), "R2 bad opcode");
    run_case(mk(8'hB0, 8'h00, 8'd0, 8'd10, '1), "R2 mode 0");
    run_case(mk(8'hB0, 8'h03, 8'd0, 8'd10, '1), "R2 mode 3");
    for (int n = 0; n < 40; n++) begin
      logic [255:0] m;
      int sel;
      logic [7:0] a, b, md;
      sel = int'($urandom % 8);
      a = 8'($urandom); b = 8'($urandom);
      m = '0;
      for (int j = 0; j < 8; j++) m[j*32 +: 32] = ($urandom % 3 == 0) ? 32'd0 : $urandom;
      if (sel == 0) begin
        md = 8'($urandom);
        if (md == 8'h01 || md == 8'h02) md = 8'h7F;
        run_case(mk(8'hB0, md, a, b, m), "R2 random mode");
      end else if (sel < 4) begin
        run_case(mk(8'hB0, 8'h01, a, b, m), "R3 random range");
      end else begin
        run_case(mk(8'hB0, 8'h02, a, b, m), "R5 random mask");
      end
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule